// File: doc/BRIEF.md
# Configurable Serial Audio Output Port

This block turns stereo PCM sample pairs into a three-wire serial audio stream: a data line, a bit clock and a left/right frame clock. Everything runs from one master clock. In master role the block divides that clock down to produce the bit clock and frame clock itself. In slave role it takes both clocks from outside, synchronises them, and follows their edges.

A small set of control inputs selects the behaviour:
- the role (master or slave);
- the frame length in bit clocks (64 or 48, master only);
- the output word length (24, 20, 18 or 16 bits);
- the frame layout.

The layouts are left-justified, I²S, right-justified (master only) and a raw pass-through. In pass-through the port re-emits receiver subframes that are already decoded, with their channel-status, user and validity bits. A block-start marker sits in the slot that normally carries the preamble.

Samples arrive as parallel 24-bit left and right words with a valid strobe. Raw subframes arrive as two 28-bit words and a block-start flag with their own strobe. A pair is taken into the output stage at the start of each frame. If nothing new has arrived, the last pair is sent again.

Top module: `audio_out_port`

## Requirements
- R1: cfgRes selects the word length: 00 gives 24 bits, 01 gives 20, 10 gives 18 and 11 gives 16. The word is the upper bits of the 24-bit sample, sent MSB first. Every slot after the LSB carries 0.
- R2: cfgFmt 00 (left-justified): the MSB is in slot 0 of each half-frame, where slot 0 is the first bit-clock rise after a frame-clock change. The frame clock is high for the left channel.
- R3: cfgFmt 01 (I²S): the MSB is in slot 1, slot 0 carries 0, and the frame clock is low for the left channel.
- R4: cfgFmt 10 (right-justified, master): the LSB is in the last slot of each half-frame, and every slot before the word carries 0. The frame clock is high for the left channel.
- R5: When right-justified is requested while cfgMaster is 0, fmtErr is 1 from the next master-clock cycle on. The format in use before the request stays in force.
- R6: cfgFmt 11 (pass-through) uses 32 slots per half-frame, with the frame clock high for left:
  - slot 0 of the left half carries the block-start flag, and slot 0 of the right half carries 0;
  - slots 1 to 3 carry 0;
  - slot 4+i carries raw bit i of that channel's 28-bit subframe, bit 0 first.
- R7: With cfgMaster 1 the block drives bclkOut and lrckOut and clkOe is 1. With cfgMaster 0, clkOe, bclkOut and lrckOut stay 0, and data timing follows bclkIn and lrckIn.
- R8: In master role a half-frame has 32 bit clocks when cfgRatio48 is 0 and 24 when it is 1. The setting is taken only while rstN is low; a change while running has no effect.
- R9: The pair last given with a strobe is taken at the start of each left half-frame. With no new strobe, the previous pair is sent again.
- R10: Data and the frame clock change only while the bit clock is low, so both are stable through each high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset; frame-length setting is taken while low |
| cfgMaster | input | 1 | 1 = block drives bit and frame clocks |
| cfgRatio48 | input | 1 | 0 = 64 bit clocks per frame, 1 = 48 (master) |
| cfgRes | input | 2 | Output word length select |
| cfgFmt | input | 2 | Frame layout select |
| sampleL | input | 24 | Left PCM sample |
| sampleR | input | 24 | Right PCM sample |
| sampleValid | input | 1 | Strobe: new PCM pair present |
| rawL | input | 28 | Left raw subframe, bit 0 sent first |
| rawR | input | 28 | Right raw subframe, bit 0 sent first |
| rawBlockStart | input | 1 | Raw pair begins a block |
| rawValid | input | 1 | Strobe: new raw pair present |
| bclkIn | input | 1 | External bit clock (slave) |
| lrckIn | input | 1 | External frame clock (slave) |
| sdata | output | 1 | Serial data |
| bclkOut | output | 1 | Generated bit clock (0 in slave) |
| lrckOut | output | 1 | Generated frame clock (0 in slave) |
| clkOe | output | 1 | Clock output enable, 1 in master |
| fmtErr | output | 1 | Right-justified requested in slave role |

## Verification
The assertions assume that cfgMaster and cfgRatio48 change only while rstN is low. They also assume that, in master role, the frame layout changes only in reset, since a live change could move the frame clock while the bit clock is high.

The stimulus applies every role, layout and ratio change through a reset sequence. The one live change is the rejected right-justified request in slave role, which leaves the active layout untouched.

In slave role the bench's own clocks change the frame clock only on bit-clock falls, with a bit-clock half period of eight master clocks. This keeps within the synchroniser latency the design relies on.

// File: rtl/aop_pkg.sv
package aop_pkg;
  localparam int SLOT_W = 6;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RAW = 2'b11
  } fmt_e;

  // strobes from control to datapath, valid in the cycle after a bit-clock fall
  typedef struct packed {
    logic              tick;
    logic              frameStart;
    logic              isLeft;
    logic              half48;
    logic [SLOT_W-1:0] slot;
  } ctl_t;
endpackage

// File: rtl/aop_control.sv
module aop_control
  import aop_pkg::*;
#(
  parameter int BCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgMaster,
  input  logic       cfgRatio48,
  input  logic [1:0] cfgFmt,
  input  logic       bclkIn,
  input  logic       lrckIn,
  output fmt_e       fmtEff,
  output logic       fmtErr,
  output logic       bclkOut,
  output logic       lrckOut,
  output ctl_t       ctl
);
  localparam int DIV_W = (BCLK_HALF < 2) ? 1 : $clog2(BCLK_HALF);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCLK_HALF - 1);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] LAST32 = SLOT_W'(31);
  localparam logic [SLOT_W-1:0] LAST24 = SLOT_W'(23);

  logic reject;
  logic leftLvl;
  logic ratio48Q;
  logic [DIV_W-1:0] divCnt;
  logic bclkQ;
  logic toggleNow;
  logic [1:0] bSync, lSync;
  logic bPrev;
  logic lTickQ;
  logic fall;
  logic [SLOT_W-1:0] slotQ, nextSlot, halfLast;
  logic rightQ, nextRight, nextLeft, newHalf;
  logic lrckQ;

  // format selection with rejection of right-justified in slave role
  assign reject = (cfgFmt == 2'b10) && !cfgMaster;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtEff <= reject ? FMT_LJ : fmt_e'(cfgFmt);
      fmtErr <= 1'b0;
    end else begin
      fmtErr <= reject;
      if (!reject) fmtEff <= fmt_e'(cfgFmt);
    end
  end

  assign leftLvl = (fmtEff != FMT_I2S);

  // frame length is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) ratio48Q <= cfgRatio48;
  end

  assign halfLast = ratio48Q ? LAST24 : LAST32;

  // bit-clock divider for master role
  always_ff @(posedge clk) begin
    if (!rstN || !cfgMaster) begin
      divCnt <= '0;
      bclkQ  <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
      bclkQ  <= ~bclkQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign toggleNow = cfgMaster && (divCnt == DIV_LAST);

  // external clock synchronisers for slave role
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
      bPrev <= 1'b0;
    end else begin
      bSync <= {bSync[0], bclkIn};
      lSync <= {lSync[0], lrckIn};
      bPrev <= bSync[1];
    end
  end

  assign fall = cfgMaster ? (toggleNow && bclkQ) : (bPrev && !bSync[1]);

  // slot and channel tracking
  always_comb begin
    if (cfgMaster) begin
      newHalf   = (slotQ == halfLast);
      nextSlot  = newHalf ? '0 : slotQ + 1'b1;
      nextRight = newHalf ? ~rightQ : rightQ;
      nextLeft  = !nextRight;
    end else begin
      newHalf   = (lSync[1] != lTickQ);
      nextSlot  = newHalf ? '0 : ((slotQ == SLOT_MAX) ? slotQ : slotQ + 1'b1);
      nextRight = rightQ;
      nextLeft  = (lSync[1] == leftLvl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ  <= cfgRatio48 ? LAST24 : LAST32;
      rightQ <= 1'b1;
      lTickQ <= 1'b0;
      lrckQ  <= 1'b0;
      ctl    <= '0;
    end else begin
      ctl.tick       <= fall;
      ctl.frameStart <= fall && newHalf && nextLeft;
      ctl.half48     <= ratio48Q;
      if (fall) begin
        slotQ      <= nextSlot;
        rightQ     <= nextRight;
        lTickQ     <= lSync[1];
        lrckQ      <= nextLeft ? leftLvl : ~leftLvl;
        ctl.isLeft <= nextLeft;
        ctl.slot   <= nextSlot;
      end
    end
  end

  assign bclkOut = cfgMaster & bclkQ;
  assign lrckOut = cfgMaster & lrckQ;
endmodule

// File: rtl/aop_datapath.sv
module aop_datapath
  import aop_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RAW_W    = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic                sampleValid,
  input  logic [RAW_W-1:0]    rawL,
  input  logic [RAW_W-1:0]    rawR,
  input  logic                rawBlockStart,
  input  logic                rawValid,
  input  logic [1:0]          cfgRes,
  input  fmt_e                fmtEff,
  input  ctl_t                ctl,
  output logic                sdata
);
  localparam int RAW_OFS = 4;

  logic [SAMPLE_W-1:0] pendL, pendR, actL, actR;
  logic [RAW_W-1:0]    pendRawL, pendRawR, actRawL, actRawR;
  logic                pendBlk, actBlk;

  logic [SAMPLE_W-1:0] word, shifted;
  logic [RAW_W-1:0]    rawWord, rawShift;
  logic                blkBit;
  int                  resBits, halfLen, slotI, k;
  logic                bitNext;

  // pending registers follow the strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL <= '0; pendR <= '0;
      pendRawL <= '0; pendRawR <= '0; pendBlk <= 1'b0;
    end else begin
      if (sampleValid) begin
        pendL <= sampleL;
        pendR <= sampleR;
      end
      if (rawValid) begin
        pendRawL <= rawL;
        pendRawR <= rawR;
        pendBlk  <= rawBlockStart;
      end
    end
  end

  // active pair is refreshed at the start of each frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actL <= '0; actR <= '0;
      actRawL <= '0; actRawR <= '0; actBlk <= 1'b0;
    end else if (ctl.tick && ctl.frameStart) begin
      actL <= pendL;
      actR <= pendR;
      actRawL <= pendRawL;
      actRawR <= pendRawR;
      actBlk  <= pendBlk;
    end
  end

  always_comb begin
    case (cfgRes)
      2'b00:   resBits = 24;
      2'b01:   resBits = 20;
      2'b10:   resBits = 18;
      default: resBits = 16;
    endcase
    if (resBits > SAMPLE_W) resBits = SAMPLE_W;
    halfLen = ctl.half48 ? 24 : 32;
    slotI   = int'(ctl.slot);

    if (ctl.isLeft) begin
      word    = ctl.frameStart ? pendL : actL;
      rawWord = ctl.frameStart ? pendRawL : actRawL;
      blkBit  = ctl.frameStart ? pendBlk : actBlk;
    end else begin
      word    = actR;
      rawWord = actRawR;
      blkBit  = 1'b0;
    end

    case (fmtEff)
      FMT_I2S: k = slotI - 1;
      FMT_RJ:  k = slotI - (halfLen - resBits);
      default: k = slotI;
    endcase

    shifted  = '0;
    rawShift = '0;
    bitNext  = 1'b0;
    if (fmtEff == FMT_RAW) begin
      if (slotI == 0) begin
        bitNext = blkBit;
      end else if (slotI >= RAW_OFS && slotI < RAW_OFS + RAW_W) begin
        rawShift = rawWord >> (slotI - RAW_OFS);
        bitNext  = rawShift[0];
      end
    end else if (k >= 0 && k < resBits) begin
      shifted = word << k;
      bitNext = shifted[SAMPLE_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sdata <= 1'b0;
    else if (ctl.tick) sdata <= bitNext;
  end
endmodule

// File: rtl/audio_out_port.sv
module audio_out_port
  import aop_pkg::*;
#(
  parameter int BCLK_HALF = 2,
  parameter int SAMPLE_W  = 24,
  parameter int RAW_W     = 28
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic                cfgRatio48,
  input  logic [1:0]          cfgRes,
  input  logic [1:0]          cfgFmt,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic                sampleValid,
  input  logic [RAW_W-1:0]    rawL,
  input  logic [RAW_W-1:0]    rawR,
  input  logic                rawBlockStart,
  input  logic                rawValid,
  input  logic                bclkIn,
  input  logic                lrckIn,
  output logic                sdata,
  output logic                bclkOut,
  output logic                lrckOut,
  output logic                clkOe,
  output logic                fmtErr
);
  fmt_e fmtEff;
  ctl_t ctl;

  aop_control #(.BCLK_HALF(BCLK_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgRatio48(cfgRatio48),
    .cfgFmt(cfgFmt), .bclkIn(bclkIn), .lrckIn(lrckIn), .fmtEff(fmtEff),
    .fmtErr(fmtErr), .bclkOut(bclkOut), .lrckOut(lrckOut), .ctl(ctl)
  );

  aop_datapath #(.SAMPLE_W(SAMPLE_W), .RAW_W(RAW_W)) u_data (
    .clk(clk), .rstN(rstN), .sampleL(sampleL), .sampleR(sampleR),
    .sampleValid(sampleValid), .rawL(rawL), .rawR(rawR),
    .rawBlockStart(rawBlockStart), .rawValid(rawValid), .cfgRes(cfgRes),
    .fmtEff(fmtEff), .ctl(ctl), .sdata(sdata)
  );

  assign clkOe = cfgMaster;
endmodule

// File: rtl/aop_checker.sv
module aop_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgMaster,
  input logic [1:0] cfgFmt,
  input logic       sdata,
  input logic       bclkOut,
  input logic       lrckOut,
  input logic       clkOe,
  input logic       fmtErr
);
  logic bPrev, lPrev, seen;
  logic [6:0] fallCnt;
  logic fallSeen, lrckTog;

  assign fallSeen = bPrev && !bclkOut;
  assign lrckTog  = (lPrev != lrckOut);

  always_ff @(posedge clk) begin
    bPrev <= bclkOut;
    lPrev <= lrckOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallCnt <= '0;
      seen    <= 1'b0;
    end else if (lrckTog) begin
      fallCnt <= 7'd1;
      seen    <= 1'b1;
    end else if (fallSeen && fallCnt != 7'h7f) begin
      fallCnt <= fallCnt + 1'b1;
    end
  end

  // R7
  slave_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkOe |-> (!bclkOut && !lrckOut));

  // R8
  half_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && seen && lrckTog) |-> (fallCnt == 7'd24 || fallCnt == 7'd32));

  // R5
  rj_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMaster && cfgFmt == 2'b10) |=> fmtErr);

  // R10
  data_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $changed(sdata)) |-> (!$past(bclkOut) && $past(bclkOut, 2)));

  // R10
  lrck_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && lrckTog) |-> !bclkOut);
endmodule

bind audio_out_port aop_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgFmt(cfgFmt),
  .sdata(sdata), .bclkOut(bclkOut), .lrckOut(lrckOut), .clkOe(clkOe),
  .fmtErr(fmtErr)
);

// File: tb/tb_audio_out_port.sv
`timescale 1ns/1ps
module tb_audio_out_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMaster = 1'b1, cfgRatio48 = 1'b0;
  logic [1:0] cfgRes = 2'b00, cfgFmt = 2'b00;
  logic [23:0] sampleL = '0, sampleR = '0;
  logic sampleValid = 1'b0;
  logic [27:0] rawL = '0, rawR = '0;
  logic rawBlockStart = 1'b0, rawValid = 1'b0;
  logic bclkDrv = 1'b0, lrckDrv = 1'b0;
  logic sdata, bclkOut, lrckOut, clkOe, fmtErr;

  int checks = 0, errors = 0;
  logic leftLvl = 1'b1;
  logic slaveOn = 1'b0;
  int sCnt = 0, sSlot = 0;

  always #5 clk = ~clk;

  audio_out_port dut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgRatio48(cfgRatio48),
    .cfgRes(cfgRes), .cfgFmt(cfgFmt), .sampleL(sampleL), .sampleR(sampleR),
    .sampleValid(sampleValid), .rawL(rawL), .rawR(rawR),
    .rawBlockStart(rawBlockStart), .rawValid(rawValid), .bclkIn(bclkDrv),
    .lrckIn(lrckDrv), .sdata(sdata), .bclkOut(bclkOut), .lrckOut(lrckOut),
    .clkOe(clkOe), .fmtErr(fmtErr)
  );

  // external clock source for slave role: half period 8 clk, 64-slot frame
  always @(negedge clk) begin
    if (!slaveOn) begin
      bclkDrv <= 1'b0; sCnt <= 0; sSlot <= 0; lrckDrv <= leftLvl;
    end else if (sCnt == 7) begin
      sCnt <= 0;
      bclkDrv <= ~bclkDrv;
      if (bclkDrv) begin
        sSlot <= (sSlot + 1) % 64;
        lrckDrv <= (((sSlot + 1) % 64) < 32) ? leftLvl : ~leftLvl;
      end
    end else begin
      sCnt <= sCnt + 1;
    end
  end

  task automatic report(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int res_len(int r);
    case (r)
      0: return 24;
      1: return 20;
      2: return 18;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] exp_half(int fmt, int res, int hl,
      logic [23:0] w, logic [27:0] raw, logic blk);
    logic [31:0] v = '0;
    int n = res_len(res);
    for (int s = 0; s < 32; s++) begin
      int k;
      if (s >= hl) continue;
      if (fmt == 3) begin
        if (s == 0) v[s] = blk;
        else if (s >= 4) v[s] = raw[s-4];
      end else begin
        if (fmt == 1) k = s - 1;
        else if (fmt == 2) k = s - (hl - n);
        else k = s;
        if (k >= 0 && k < n) v[s] = w[23-k];
      end
    end
    return v;
  endfunction

  task automatic reset_dut(logic m, logic r48, int fmt, int res);
    slaveOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    cfgMaster = m; cfgRatio48 = r48;
    cfgFmt = fmt[1:0]; cfgRes = res[1:0];
    leftLvl = (fmt != 1);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    if (!m) slaveOn = 1'b1;
  endtask

  task automatic send_pair(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    sampleL = l; sampleR = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic send_raw(logic [27:0] l, logic [27:0] r, logic blk);
    @(negedge clk);
    rawL = l; rawR = r; rawBlockStart = blk; rawValid = 1'b1;
    @(negedge clk);
    rawValid = 1'b0;
  endtask

  task automatic get_bit(output logic d, output logic l);
    if (cfgMaster) @(posedge bclkOut);
    else @(posedge bclkDrv);
    #1;
    d = sdata;
    l = cfgMaster ? lrckOut : lrckDrv;
  endtask

  task automatic capture(output logic [31:0] lb, output logic [31:0] rb,
                         output int ln, output int rn);
    logic d, l, pl;
    lb = '0; rb = '0; ln = 0; rn = 0;
    get_bit(d, pl);
    while (1) begin
      get_bit(d, l);
      if (l == leftLvl && pl != leftLvl) break;
      pl = l;
    end
    lb[0] = d; ln = 1;
    while (1) begin
      get_bit(d, l);
      if (l != leftLvl) break;
      if (ln < 32) lb[ln] = d;
      ln++;
    end
    rb[0] = d; rn = 1;
    while (1) begin
      get_bit(d, l);
      if (l == leftLvl) break;
      if (rn < 32) rb[rn] = d;
      rn++;
    end
  endtask

  // skips one frame so the latched pair is settled, then checks a full frame
  task automatic check_frame(string tag, int fmt, int res, int hl,
      logic [23:0] l, logic [23:0] r, logic [27:0] rl, logic [27:0] rr, logic blk);
    logic [31:0] lb, rb;
    int ln, rn;
    capture(lb, rb, ln, rn);
    capture(lb, rb, ln, rn);
    report({tag, " left word"}, {32'h0, lb}, {32'h0, exp_half(fmt, res, hl, l, rl, blk)});
    report({tag, " right word"}, {32'h0, rb}, {32'h0, exp_half(fmt, res, hl, r, rr, 1'b0)});
    report({tag, " half length"}, 64'(ln * 256 + rn), 64'(hl * 256 + hl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] a, b;
    void'($urandom(32'h5eed_1234));

    // reset state
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    report("reset R7 outputs", {60'h0, sdata, bclkOut, lrckOut, fmtErr}, 64'h0);
    report("reset R7 clkOe", {63'h0, clkOe}, 64'h1);

    // R2 left-justified, 24-bit, 64 frame
    reset_dut(1'b1, 1'b0, 0, 0);
    a = 24'hA5C3_96; b = 24'h1234_56;
    send_pair(a, b);
    check_frame("R2 LJ 24b", 0, 0, 32, a, b, '0, '0, 1'b0);
    // R9 repeat without new strobe
    check_frame("R9 repeat pair", 0, 0, 32, a, b, '0, '0, 1'b0);
    // R9 new pair latched
    send_pair(24'h00_0001, 24'h80_0000);
    check_frame("R9 new pair", 0, 0, 32, 24'h00_0001, 24'h80_0000, '0, '0, 1'b0);

    // R10 stability through the bit-clock high phase
    begin
      int bad = 0;
      logic hd = 1'b0, hl = 1'b0, pb = 1'b0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (bclkOut && !pb) begin hd = sdata; hl = lrckOut; end
        else if (bclkOut && pb && (sdata !== hd || lrckOut !== hl)) bad++;
        pb = bclkOut;
      end
      report("R10 stable while bclk high", 64'(bad), 64'h0);
    end

    // R1 resolution truncation
    reset_dut(1'b1, 1'b0, 0, 3);
    send_pair(24'hFFFF_FF, 24'hC0FF_EE);
    check_frame("R1 LJ 16b", 0, 3, 32, 24'hFFFF_FF, 24'hC0FF_EE, '0, '0, 1'b0);
    reset_dut(1'b1, 1'b0, 0, 2);
    send_pair(24'hFFFF_FF, 24'h7FFF_FF);
    check_frame("R1 LJ 18b", 0, 2, 32, 24'hFFFF_FF, 24'h7FFF_FF, '0, '0, 1'b0);

    // R3 I2S, 20-bit
    reset_dut(1'b1, 1'b0, 1, 1);
    send_pair(24'hF0F0_F0, 24'h0F0F_0F);
    check_frame("R3 I2S 20b", 1, 1, 32, 24'hF0F0_F0, 24'h0F0F_0F, '0, '0, 1'b0);

    // R4 right-justified, 16-bit, 64 frame
    reset_dut(1'b1, 1'b0, 2, 3);
    send_pair(24'hABCD_EF, 24'h8001_FF);
    check_frame("R4 RJ 16b", 2, 3, 32, 24'hABCD_EF, 24'h8001_FF, '0, '0, 1'b0);

    // R4 R8 right-justified 24-bit filling a 24-slot half
    reset_dut(1'b1, 1'b1, 2, 0);
    send_pair(24'h9ABC_DE, 24'h3579_BD);
    check_frame("R4 R8 RJ 48-frame", 2, 0, 24, 24'h9ABC_DE, 24'h3579_BD, '0, '0, 1'b0);
    // R8 ratio change while running is ignored
    @(negedge clk) cfgRatio48 = 1'b0;
    check_frame("R8 ratio live change", 2, 0, 24, 24'h9ABC_DE, 24'h3579_BD, '0, '0, 1'b0);

    // R6 pass-through
    reset_dut(1'b1, 1'b0, 3, 0);
    send_raw(28'hA5A_5A5A, 28'h123_4567, 1'b1);
    check_frame("R6 raw block start", 3, 0, 32, '0, '0, 28'hA5A_5A5A, 28'h123_4567, 1'b1);
    send_raw(28'hFFF_FFFF, 28'h800_0001, 1'b0);
    check_frame("R6 raw no block", 3, 0, 32, '0, '0, 28'hFFF_FFFF, 28'h800_0001, 1'b0);

    // R7 slave role follows external clocks
    reset_dut(1'b0, 1'b0, 0, 0);
    send_pair(24'hDEAD_BE, 24'h5A5A_5A);
    repeat (4) @(negedge clk);
    report("R7 slave clocks quiet", {61'h0, clkOe, bclkOut, lrckOut}, 64'h0);
    check_frame("R7 slave LJ", 0, 0, 32, 24'hDEAD_BE, 24'h5A5A_5A, '0, '0, 1'b0);

    // R5 right-justified rejected in slave role
    @(negedge clk) cfgFmt = 2'b10;
    @(negedge clk);
    @(negedge clk);
    report("R5 fmtErr raised", {63'h0, fmtErr}, 64'h1);
    check_frame("R5 previous format kept", 0, 0, 32, 24'hDEAD_BE, 24'h5A5A_5A, '0, '0, 1'b0);

    // random configurations in master role
    for (int it = 0; it < 30; it++) begin
      int fmt = $urandom_range(0, 3);
      int res = $urandom_range(0, 3);
      logic r48 = 1'($urandom_range(0, 1));
      logic [23:0] rl = 24'($urandom);
      logic [23:0] rr = 24'($urandom);
      logic [27:0] wl = 28'($urandom);
      logic [27:0] wr = 28'($urandom);
      logic bk = 1'($urandom_range(0, 1));
      int hl = r48 ? 24 : 32;
      reset_dut(1'b1, r48, fmt, res);
      send_pair(rl, rr);
      send_raw(wl, wr, bk);
      check_frame($sformatf("R1 R2 R3 R4 R6 R8 random fmt%0d res%0d", fmt, res),
                  fmt, res, hl, rl, rr, wl, wr, bk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule